// File: doc/BRIEF.md
# Quad Down-Counting Timer Peripheral

This block holds four independent down-counters behind a plain 32-bit register read/write port. Every channel has a load register, a readable count, a control register and a background reload register. A channel runs free, periodic or single-shot. Its count steps are taken from a shared tick-enable input through a per-channel divider of 1, 16 or 256, and the count can be 32 or 16 bits wide.

When a channel's count steps from one to zero it raises its raw status bit. Free-running channels then wrap to the maximum value. Periodic channels reload from the background register, so software can change the next period without disturbing the period already under way. Single-shot channels stop at zero. A shared interrupt section holds a mask, the raw status, the masked status and a write-one-to-clear register. A single interrupt line is high whenever any masked bit is set.

Accesses take one cycle. A write is taken on the clock edge at which `wr_en` is high. A read presents the addressed register on `rdata` after the edge at which `rd_en` is high, and `rdata` holds that value until the next read.

Top module: `quad_dtimer`

## Requirements
- R1: Register map, all word-aligned with address bits 1:0 zero. The interrupt mask is at 0x00, raw status at 0x04, masked status at 0x08 and write-one-to-clear at 0x0C, which reads zero. Channel n (0..3) has load at 0x10+0x10*n, count at +0x4, control at +0x8 and background reload at +0xC. Bit n of each interrupt register belongs to channel n. Every register reads zero after reset.
- R2: A load write sets both the count and the background register at once. The count takes the value masked to the current width, and the load register reads back the full written value.
- R3: While the channel is enabled, every divided tick lowers the count by one.
- R4: Control bits 3:2 set the divider: 00 steps on every tick, 01 on every 16th tick and 10 or 11 on every 256th tick.
- R5: Control bit 7 enables the channel. While it is clear the count is frozen and the divider phase is held at zero, so after the channel is enabled again the first step comes after a full divider period.
- R6: In free-running mode (bits 6 and 0 clear), a step from zero wraps the count to 0xFFFFFFFF, or to 0xFFFF in 16-bit mode.
- R7: In periodic mode (bit 6 set, bit 0 clear), a step from one or zero loads the background value. A write to the background register alone leaves the running count unchanged and takes effect at the next reload.
- R8: In single-shot mode (bit 0 set, which takes priority over bit 6), the count stops at zero until a new load.
- R9: With control bit 1 clear, only the low 16 bits count and the upper 16 bits of the count read zero. With bit 1 set, all 32 bits count.
- R10: A step that takes the count from one sets that channel's raw status bit. The bit stays set until it is cleared.
- R11: Masked status reads raw AND mask, and `irq_out` equals the OR of the masked bits in every cycle.
- R12: Writing a 1 to bit n at 0x0C clears raw bit n. Bits written as 0 are unaffected. A new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count tick enable, shared by all channels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The assertions assume that `wr_en` is never high for an address outside the map. They also assume that no load write and clear of the same channel is needed to behave in any particular order beyond the stated event-wins rule. The bench keeps `tick_en` low during every register access, so counts move only inside the tick bursts it issues. Before each scenario it disables every channel it no longer uses, so a shared tick never moves a channel that another check reads.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;
  localparam int CTL_ENA  = 7;
  localparam int CTL_PER  = 6;
  localparam int CTL_PRE  = 2;
  localparam int CTL_WIDE = 1;
  localparam int CTL_ONE  = 0;

  typedef struct packed {
    logic       ena;
    logic       per;
    logic [1:0] pre;
    logic       wide;
    logic       one;
  } ctl_t;

  function automatic ctl_t ctl_decode(input logic [7:0] b);
    ctl_t c;
    c.ena  = b[CTL_ENA];
    c.per  = b[CTL_PER];
    c.pre  = b[CTL_PRE+1:CTL_PRE];
    c.wide = b[CTL_WIDE];
    c.one  = b[CTL_ONE];
    return c;
  endfunction

  function automatic logic [7:0] ctl_encode(input ctl_t c);
    return {c.ena, c.per, 2'b00, c.pre, c.wide, c.one};
  endfunction
endpackage

// File: rtl/qtmr_prescale.sv
module qtmr_prescale #(
  parameter int PRE_LOG2 = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       step
);
  localparam int PW = PRE_LOG2;
  localparam logic [PW-1:0] TERM_MID = PW'((1 << (PRE_LOG2/2)) - 1);
  localparam logic [PW-1:0] TERM_MAX = PW'((1 << PRE_LOG2) - 1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] term;

  always_comb begin
    case (sel)
      2'b00:   term = '0;
      2'b01:   term = TERM_MID;
      default: term = TERM_MAX;
    endcase
  end

  assign step = run && (phase_q == term);

  always_ff @(posedge clk) begin
    if (rst || clr) phase_q <= '0;
    else if (run)   phase_q <= step ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/qtmr_channel.sv
module qtmr_channel
  import qtmr_pkg::*;
#(
  parameter int CW       = 32,
  parameter int NW       = 16,
  parameter int PRE_LOG2 = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          wr_ld,
  input  logic          wr_bg,
  input  logic          wr_ctl,
  input  logic [CW-1:0] wdata,
  output ctl_t          ctl_q,
  output logic [CW-1:0] ld_q,
  output logic [CW-1:0] bg_q,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cur,
  output logic          evt
);
  localparam logic [CW-1:0] NMASK = {{(CW-NW){1'b0}}, {NW{1'b1}}};

  logic [CW-1:0] wmask;
  logic [CW-1:0] nxt;
  logic          step;

  assign wmask = ctl_q.wide ? '1 : NMASK;
  assign cur   = cnt_q & wmask;

  qtmr_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (tick_en && ctl_q.ena),
    .clr  (!ctl_q.ena || wr_ld),
    .sel  (ctl_q.pre),
    .step (step)
  );

  assign evt = step && !wr_ld && (cur == CW'(1));

  always_comb begin
    if (ctl_q.one)
      nxt = (cur == '0) ? cur : cur - CW'(1);
    else if (ctl_q.per && cur <= CW'(1))
      nxt = bg_q & wmask;
    else
      nxt = (cur - CW'(1)) & wmask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      ld_q  <= '0;
      bg_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= ctl_decode(wdata[7:0]);
      if (wr_ld) begin
        ld_q  <= wdata;
        bg_q  <= wdata;
        cnt_q <= wdata & wmask;
      end else begin
        if (wr_bg) bg_q  <= wdata;
        if (step)  cnt_q <= nxt;
      end
    end
  end
endmodule

// File: rtl/qtmr_irq.sv
module qtmr_irq #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_mask,
  input  logic           wr_clr,
  input  logic [NCH-1:0] wbits,
  input  logic [NCH-1:0] evt,
  output logic [NCH-1:0] raw_q,
  output logic [NCH-1:0] mask_q,
  output logic           irq_q
);
  logic [NCH-1:0] raw_d;
  logic [NCH-1:0] mask_d;

  assign raw_d  = (raw_q & ~(wr_clr ? wbits : '0)) | evt;
  assign mask_d = wr_mask ? wbits : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      irq_q  <= |(raw_d & mask_d);
    end
  end
endmodule

// File: rtl/quad_dtimer.sv
module quad_dtimer
  import qtmr_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DW       = 32,
  parameter int NW       = 16,
  parameter int ADDR_W   = 8,
  parameter int PRE_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq_out
);
  localparam int RW = ADDR_W - 4;

  logic [RW-1:0] region;
  logic [1:0]    fld;
  logic          aligned;

  assign region  = addr[ADDR_W-1:4];
  assign fld     = addr[3:2];
  assign aligned = (addr[1:0] == 2'b00);

  logic [NCH-1:0]         ch_evt;
  logic [NCH-1:0]         ch_ena;
  logic [NCH-1:0]         ch_one;
  logic [NCH-1:0]         ld_wr;
  logic [NCH-1:0][DW-1:0] ch_val;
  logic [NCH-1:0][DW-1:0] ch_cur;
  logic [NCH-1:0][DW-1:0] ch_ld;
  logic [NCH-1:0][DW-1:0] ch_bg;
  ctl_t [NCH-1:0]         ch_ctl;

  logic [NCH-1:0] raw_q;
  logic [NCH-1:0] mask_q;

  logic glob_wr;
  assign glob_wr = wr_en && aligned && (region == '0);

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_ch
      logic hit;
      assign hit       = wr_en && aligned && (region == RW'(gi + 1));
      assign ld_wr[gi] = hit && (fld == 2'd0);

      qtmr_channel #(.CW(DW), .NW(NW), .PRE_LOG2(PRE_LOG2)) u_ch (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .wr_ld   (ld_wr[gi]),
        .wr_bg   (hit && (fld == 2'd3)),
        .wr_ctl  (hit && (fld == 2'd2)),
        .wdata   (wdata),
        .ctl_q   (ch_ctl[gi]),
        .ld_q    (ch_ld[gi]),
        .bg_q    (ch_bg[gi]),
        .cnt_q   (ch_val[gi]),
        .cur     (ch_cur[gi]),
        .evt     (ch_evt[gi])
      );
      assign ch_ena[gi] = ch_ctl[gi].ena;
      assign ch_one[gi] = ch_ctl[gi].one;
    end
  endgenerate

  qtmr_irq #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .wr_mask (glob_wr && (fld == 2'd0)),
    .wr_clr  (glob_wr && (fld == 2'd3)),
    .wbits   (wdata[NCH-1:0]),
    .evt     (ch_evt),
    .raw_q   (raw_q),
    .mask_q  (mask_q),
    .irq_q   (irq_out)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (region == '0) begin
        case (fld)
          2'd0:    rd_mux = DW'(mask_q);
          2'd1:    rd_mux = DW'(raw_q);
          2'd2:    rd_mux = DW'(raw_q & mask_q);
          default: rd_mux = '0;
        endcase
      end
      for (int i = 0; i < NCH; i++) begin
        if (region == RW'(i + 1)) begin
          case (fld)
            2'd0:    rd_mux = ch_ld[i];
            2'd1:    rd_mux = ch_cur[i];
            2'd2:    rd_mux = DW'(ctl_encode(ch_ctl[i]));
            default: rd_mux = ch_bg[i];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/quad_dtimer_chk.sv
module quad_dtimer_chk #(
  parameter int NCH    = 4,
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      addr,
  input logic [DW-1:0]          wdata,
  input logic                   irq_out,
  input logic [NCH-1:0]         raw,
  input logic [NCH-1:0]         mask,
  input logic [NCH-1:0]         evt,
  input logic [NCH-1:0]         ena,
  input logic [NCH-1:0]         one,
  input logic [NCH-1:0]         ld_wr,
  input logic [NCH-1:0][DW-1:0] val
);
  logic clr_wr;
  assign clr_wr = wr_en && (addr == ADDR_W'(12));

  AST_IRQ_IS_MASKED_OR: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(raw & mask)); // R11

  AST_EVENT_SETS_RAW: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((raw & $past(evt)) == $past(evt))); // R10

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((raw & $past(raw)) == $past(raw))); // R12

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((raw & $past(wdata[NCH-1:0] & ~evt)) == '0)); // R12

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_chk
      AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!ena[gi] && !ld_wr[gi]) |=> $stable(val[gi])); // R5

      AST_ONESHOT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ena[gi] && one[gi] && val[gi] == '0 && !ld_wr[gi]) |=> (val[gi] == '0)); // R8
    end
  endgenerate
endmodule

bind quad_dtimer quad_dtimer_chk #(.NCH(NCH), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .irq_out (irq_out),
  .raw     (raw_q),
  .mask    (mask_q),
  .evt     (ch_evt),
  .ena     (ch_ena),
  .one     (ch_one),
  .ld_wr   (ld_wr),
  .val     (ch_val)
);

// File: tb/quad_dtimer_bench.sv
module quad_dtimer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [31:0] ENA = 32'h80, PER = 32'h40, P16 = 32'h04,
                          P256 = 32'h08, W32 = 32'h02, ONE = 32'h01;
  localparam logic [7:0] A_MASK = 8'h00, A_RAW = 8'h04, A_MIS = 8'h08, A_CLR = 8'h0C;

  quad_dtimer u_quad_dtimer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] ra(input int ch, input int f);
    return 8'(16 + 16*ch + 4*f);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    expect_rd("R1 ctrl0 reset", ra(0, 2), 32'h0);
    expect_rd("R1 count3 reset", ra(3, 1), 32'h0);
    expect_rd("R1 raw reset", A_RAW, 32'h0);
    check("R1 irq reset", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_load_count();
    wr(ra(0, 2), ENA | W32);
    wr(ra(0, 0), 32'd10);
    expect_rd("R2 count after load", ra(0, 1), 32'd10);
    expect_rd("R2 bg copy of load", ra(0, 3), 32'd10);
    ticks(3);
    expect_rd("R3 count after 3 steps", ra(0, 1), 32'd7);
    expect_rd("R1 ctrl readback", ra(0, 2), ENA | W32);
    wr(ra(0, 2), 32'h0);
  endtask

  task automatic t_free16();
    wr(ra(1, 2), ENA);
    wr(ra(1, 0), 32'h12345);
    expect_rd("R9 upper bits read zero", ra(1, 1), 32'h2345);
    expect_rd("R2 load reg full value", ra(1, 0), 32'h12345);
    wr(ra(1, 0), 32'd2);
    ticks(2);
    expect_rd("R10 free reach zero", ra(1, 1), 32'd0);
    expect_rd("R10 raw bit1", A_RAW, 32'h2);
    ticks(1);
    expect_rd("R6 R9 wrap to 0xFFFF", ra(1, 1), 32'hFFFF);
    wr(ra(1, 2), 32'h0);
  endtask

  task automatic t_periodic();
    wr(ra(2, 2), ENA | PER | W32);
    wr(ra(2, 0), 32'd3);
    ticks(3);
    expect_rd("R7 reload at end", ra(2, 1), 32'd3);
    expect_rd("R10 raw bit2", A_RAW, 32'h6);
    wr(ra(2, 3), 32'd5);
    expect_rd("R7 bg write keeps count", ra(2, 1), 32'd3);
    expect_rd("R7 bg readback", ra(2, 3), 32'd5);
    ticks(3);
    expect_rd("R7 new bg at reload", ra(2, 1), 32'd5);
    ticks(2);
    expect_rd("R7 mid period", ra(2, 1), 32'd3);
    wr(ra(2, 2), 32'h0);
  endtask

  task automatic t_oneshot();
    wr(ra(3, 2), ENA | W32 | ONE | PER);
    wr(ra(3, 0), 32'd2);
    ticks(2);
    expect_rd("R8 oneshot zero", ra(3, 1), 32'd0);
    ticks(5);
    expect_rd("R8 oneshot holds", ra(3, 1), 32'd0);
    expect_rd("R10 raw bit3", A_RAW, 32'hE);
    wr(ra(3, 0), 32'd4);
    ticks(1);
    expect_rd("R8 restart after load", ra(3, 1), 32'd3);
    wr(ra(3, 2), 32'h0);
  endtask

  task automatic t_prescale();
    wr(ra(0, 2), ENA | W32 | P16);
    wr(ra(0, 0), 32'd100);
    ticks(15);
    expect_rd("R4 div16 before step", ra(0, 1), 32'd100);
    ticks(1);
    expect_rd("R4 div16 step", ra(0, 1), 32'd99);
    ticks(32);
    expect_rd("R4 div16 two more", ra(0, 1), 32'd97);
    wr(ra(0, 2), ENA | W32 | P256);
    wr(ra(0, 0), 32'd10);
    ticks(255);
    expect_rd("R4 div256 before step", ra(0, 1), 32'd10);
    ticks(1);
    expect_rd("R4 div256 step", ra(0, 1), 32'd9);
    wr(ra(0, 2), 32'h0);
  endtask

  task automatic t_freeze();
    wr(ra(0, 2), ENA | W32 | P16);
    wr(ra(0, 0), 32'd50);
    ticks(10);
    wr(ra(0, 2), W32 | P16);
    ticks(20);
    expect_rd("R5 frozen while off", ra(0, 1), 32'd50);
    wr(ra(0, 2), ENA | W32 | P16);
    ticks(15);
    expect_rd("R5 divider phase restarted", ra(0, 1), 32'd50);
    ticks(1);
    expect_rd("R5 first step after enable", ra(0, 1), 32'd49);
    wr(ra(0, 2), 32'h0);
  endtask

  task automatic t_irq();
    wr(A_CLR, 32'hF);
    expect_rd("R12 clear all", A_RAW, 32'h0);
    wr(ra(1, 2), ENA | W32);
    wr(ra(1, 0), 32'd1);
    ticks(1);
    expect_rd("R10 raw on event", A_RAW, 32'h2);
    check("R11 irq low when masked off", {31'b0, irq_out}, 32'h0);
    expect_rd("R11 masked zero", A_MIS, 32'h0);
    ticks(1);
    expect_rd("R6 wrap to all ones", ra(1, 1), 32'hFFFFFFFF);
    wr(A_MASK, 32'h2);
    check("R11 irq high", {31'b0, irq_out}, 32'h1);
    expect_rd("R11 masked status", A_MIS, 32'h2);
    expect_rd("R1 mask readback", A_MASK, 32'h2);
    wr(A_CLR, 32'h1);
    expect_rd("R12 zero bits untouched", A_RAW, 32'h2);
    wr(A_CLR, 32'h2);
    expect_rd("R12 bit cleared", A_RAW, 32'h0);
    check("R11 irq drops", {31'b0, irq_out}, 32'h0);
    expect_rd("R1 clear reg reads zero", A_CLR, 32'h0);
    wr(ra(1, 2), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_count();
    t_free16();
    t_periodic();
    t_oneshot();
    t_prescale();
    t_freeze();
    t_irq();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule